// File: doc/BRIEF.md
# Banked Nibble Real-Time Clock Register File

This block is a real-time-clock peripheral with a 4-bit data bus and sixteen register addresses. Every location holds one nibble. A control word at address 0xD picks one of four banks for the thirteen low addresses (0x0 to 0xC). The banks are the BCD time and calendar digits, the alarm and configuration registers, and two independent scratch RAM blocks. The control word, a spare test nibble and an action register sit at 0xD, 0xE and 0xF, and these three addresses reach the same storage whatever bank is selected.

A free-running oscillator tick enters on `osc_tick`. A prescaler of `DIV_STEPS` stages divides it down to one step per second while timekeeping is enabled. The step ripples through the BCD digit counters: seconds, minutes, hours (24-hour, or 12-hour with a PM flag), day of week, day of month with month-length and leap-year rules, month and year. Software stops timekeeping, writes digits directly, and starts it again. A simple comparator raises `alarm_hit` when the armed alarm digits match the running time at the top of a minute. Two pulse outputs mirror the oscillator tick and the seconds step, and each can be silenced.

Top module: `banked_rtc`

## Requirements
- R1: After reset the control word reads 0, so bank 00 is selected and timekeeping and the alarm are off. The time bank reads 00:00:00 with day 01, month 01, year 00 and day of week 0.
- R2: Control word bits [1:0] pick the bank seen at 0x0–0xC: 00 time digits, 01 alarm/configuration, 10 RAM block A, 11 RAM block B. Addresses 0xD (control word, reads back all 4 bits) and 0xE (test nibble, reads back all 4 bits) reach the same storage in every bank.
- R3: RAM blocks A and B each hold 13 nibbles at 0x0–0xC, and a write to one never changes the other.
- R4: With control bit 3 set, every `DIV_STEPS` pulses of `osc_tick` advance the seconds by one. With bit 3 clear the time digits hold, and pulses arriving then are dropped with no catch-up later.
- R5: Seconds and minutes roll from 59 to 00 and carry. In 24-hour mode the hours roll from 23 to 00 and carry into the day.
- R6: Bank 01 address 0xA bit 0 set selects 24-hour mode, and clear selects 12-hour mode. In 12-hour mode bit 1 of the 10-hour digit (address 0x5) is the PM flag and bit 0 is the tens. 11 goes to 12 and toggles PM, 12 goes to 1, and 11 PM to 12 AM carries into the day.
- R7: Days run 1 to the month length: 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 29 when the leap counter (bank 01 address 0xB, bits [1:0]) is 0 and 28 otherwise. Month 12 rolls to 1 and carries into the year. The year rolls from 99 to 00, and each year carry adds one (mod 4) to the leap counter. Day of week (address 0x6) counts 0 to 6 and wraps on each day carry.
- R8: A write to any time-bank digit loads the written value directly.
- R9: `alarm_hit` is high exactly when control bit 2 is set, the seconds are 00, and alarm digits at bank 01 addresses 0x2–0x8 equal the time digits at the same addresses.
- R10: Writing address 0xF with bit 0 set clears all alarm digits. Bit 1 set restarts the prescaler from zero. Bits 3 and 2 are stored: bit 2 set silences `pulse_16hz` and bit 3 set silences `pulse_1hz`. Address 0xF reads bits 3:2 back, with bits 1:0 reading 0.
- R11: `pulse_16hz` is high for the cycle after each `osc_tick`, and `pulse_1hz` is high for the cycle after each seconds step, unless silenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle oscillator tick, `DIV_STEPS` per second |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 4 | Read data for `bus_addr` (combinational) |
| alarm_hit | output | 1 | Alarm comparator result |
| pulse_16hz | output | 1 | Registered copy of the oscillator tick |
| pulse_1hz | output | 1 | Registered seconds-step pulse |

## Verification
The hardest conditions to reach are the deep carry chains: a rollover from the last second of a year, February 29 in a leap year, and the 11 PM to 12 AM change in 12-hour mode. Waiting for these from reset would take far too long, so the stimulus stops timekeeping, loads each digit one step before the boundary, re-enables the clock and supplies exactly one second's worth of oscillator ticks. The dropped-tick rule and the prescaler restart are checked by supplying tick counts that give a different seconds value if any stale prescaler count survived.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NIB_W    = 4;
    localparam int LOW_REGS = 13;
    localparam int ALM_REGS = 7;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        BANK_TIME = 2'b00,
        BANK_CFG  = 2'b01,
        BANK_RAMA = 2'b10,
        BANK_RAMB = 2'b11
    } bank_e;

    localparam logic [3:0] A_CTRL  = 4'hD;
    localparam logic [3:0] A_TEST  = 4'hE;
    localparam logic [3:0] A_ACT   = 4'hF;
    localparam logic [3:0] A_H24   = 4'hA;
    localparam logic [3:0] A_LEAP  = 4'hB;
    localparam logic [3:0] A_ALM_LO = 4'h2;
    localparam logic [3:0] A_ALM_HI = 4'h8;

    // time digit positions; the carry chain depends on them
    localparam int D_S1  = 0;
    localparam int D_S10 = 1;
    localparam int D_M1  = 2;
    localparam int D_M10 = 3;
    localparam int D_H1  = 4;
    localparam int D_H10 = 5;
    localparam int D_DOW = 6;
    localparam int D_D1  = 7;
    localparam int D_D10 = 8;
    localparam int D_MO1 = 9;
    localparam int D_MO10 = 10;
    localparam int D_Y1  = 11;
    localparam int D_Y10 = 12;

    function automatic logic [7:0] bcd_to_bin(input nib_t tens, input nib_t ones);
        return ({4'd0, tens} * 8'd10) + {4'd0, ones};
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] o;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [1:0] leap);
        logic [7:0] r;
        case (mon)
            8'd2:                      r = (leap == 2'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   r = 8'd30;
            default:                   r = 8'd31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clr,
    output logic sec_step
);
    localparam int CW = (DIV_STEPS > 1) ? $clog2(DIV_STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_STEPS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t q, d;

    always_comb begin
        d        = q;
        sec_step = 1'b0;
        if (clr) begin
            d.cnt = '0;
        end else if (tick && run) begin
            if (q.cnt == LAST) begin
                d.cnt    = '0;
                sec_step = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic                       mode24,
    input  logic                       wr_en,
    input  logic [3:0]                 wr_idx,
    input  nib_t                       wr_nib,
    input  logic                       leap_we,
    input  logic [1:0]                 leap_nib,
    output logic [LOW_REGS-1:0][3:0]   digits,
    output logic [1:0]                 leap
);
    typedef struct packed {
        logic [LOW_REGS-1:0][3:0] dig;
        logic [1:0]               leap;
    } tc_t;

    tc_t q, d;

    logic [7:0] sec_b, min_b, hr24_b, hr12_b, day_b, mon_b, yr_b, dim_b, hr_n, hb;
    logic       c_min, c_hr, c_day, c_mon, c_yr, pm_n;

    always_comb begin
        d      = q;
        sec_b  = bcd_to_bin(q.dig[D_S10], q.dig[D_S1]);
        min_b  = bcd_to_bin(q.dig[D_M10], q.dig[D_M1]);
        hr24_b = bcd_to_bin(q.dig[D_H10], q.dig[D_H1]);
        hr12_b = bcd_to_bin({3'b000, q.dig[D_H10][0]}, q.dig[D_H1]);
        day_b  = bcd_to_bin(q.dig[D_D10], q.dig[D_D1]);
        mon_b  = bcd_to_bin(q.dig[D_MO10], q.dig[D_MO1]);
        yr_b   = bcd_to_bin(q.dig[D_Y10], q.dig[D_Y1]);
        dim_b  = month_days(mon_b, q.leap);
        c_min  = 1'b0;
        c_hr   = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_yr   = 1'b0;
        hr_n   = '0;
        hb     = '0;
        pm_n   = q.dig[D_H10][1];

        if (step) begin
            c_min = (sec_b >= 8'd59);
            {d.dig[D_S10], d.dig[D_S1]} = bin_to_bcd(c_min ? 8'd0 : sec_b + 8'd1);
        end
        if (c_min) begin
            c_hr = (min_b >= 8'd59);
            {d.dig[D_M10], d.dig[D_M1]} = bin_to_bcd(c_hr ? 8'd0 : min_b + 8'd1);
        end
        if (c_hr) begin
            if (mode24) begin
                c_day = (hr24_b >= 8'd23);
                {d.dig[D_H10], d.dig[D_H1]} = bin_to_bcd(c_day ? 8'd0 : hr24_b + 8'd1);
            end else begin
                if (hr12_b == 8'd11) begin
                    hr_n  = 8'd12;
                    pm_n  = ~q.dig[D_H10][1];
                    c_day = q.dig[D_H10][1];
                end else if (hr12_b >= 8'd12) begin
                    hr_n = 8'd1;
                end else begin
                    hr_n = hr12_b + 8'd1;
                end
                hb = bin_to_bcd(hr_n);
                d.dig[D_H10] = {2'b00, pm_n, |hb[7:4]};
                d.dig[D_H1]  = hb[3:0];
            end
        end
        if (c_day) begin
            d.dig[D_DOW] = (q.dig[D_DOW] >= 4'd6) ? 4'd0 : q.dig[D_DOW] + 4'd1;
            c_mon = (day_b >= dim_b);
            {d.dig[D_D10], d.dig[D_D1]} = bin_to_bcd(c_mon ? 8'd1 : day_b + 8'd1);
        end
        if (c_mon) begin
            c_yr = (mon_b >= 8'd12);
            {d.dig[D_MO10], d.dig[D_MO1]} = bin_to_bcd(c_yr ? 8'd1 : mon_b + 8'd1);
        end
        if (c_yr) begin
            {d.dig[D_Y10], d.dig[D_Y1]} = bin_to_bcd((yr_b >= 8'd99) ? 8'd0 : yr_b + 8'd1);
            d.leap = q.leap + 2'd1;
        end

        if (wr_en) d.dig[wr_idx] = wr_nib;
        if (leap_we) d.leap = leap_nib;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q             <= '0;
            q.dig[D_D1]   <= 4'd1;
            q.dig[D_MO1]  <= 4'd1;
        end else begin
            q <= d;
        end
    end

    assign digits = q.dig;
    assign leap   = q.leap;
endmodule

// File: rtl/rtc_nibble_ram.sv
module rtc_nibble_ram #(
    parameter int DEPTH = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    output logic [3:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][3:0] mem;
    } ram_t;

    ram_t q, d;

    always_comb begin
        d = q;
        if (we && (32'(addr) < DEPTH)) d.mem[addr] = wdata;
        rdata = (32'(addr) < DEPTH) ? q.mem[addr] : 4'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/banked_rtc.sv
module banked_rtc
    import rtc_pkg::*;
#(
    parameter int DIV_STEPS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [3:0] bus_addr,
    input  logic [3:0] bus_wdata,
    input  logic       bus_we,
    output logic [3:0] bus_rdata,
    output logic       alarm_hit,
    output logic       pulse_16hz,
    output logic       pulse_1hz
);
    localparam int RAM_BLOCKS = 2;

    typedef struct packed {
        nib_t                     ctrl;
        nib_t                     test;
        logic [1:0]               mute;   // [1] seconds pulse, [0] oscillator pulse
        logic                     h24;
        logic [ALM_REGS-1:0][3:0] alarm;
        logic                     p16;
        logic                     p1;
    } ctl_t;

    ctl_t q, d;

    logic                     low_addr;
    bank_e                    bank;
    logic [2:0]               aidx;
    logic                     in_alm;
    logic                     time_we, leap_we, div_clr, sec_step;
    logic [RAM_BLOCKS-1:0]    ram_we;
    logic [3:0]               ram_rd [RAM_BLOCKS];
    logic [LOW_REGS-1:0][3:0] time_dig;
    logic [1:0]               leap;
    logic [3:0]               mode_cur;
    logic [1:0]               mute_cur;
    logic [ALM_REGS-1:0][3:0] alarm_cur;

    assign low_addr  = (32'(bus_addr) < LOW_REGS);
    assign bank      = bank_e'(q.ctrl[1:0]);
    assign aidx      = 3'(bus_addr - A_ALM_LO);
    assign in_alm    = (bus_addr >= A_ALM_LO) && (bus_addr <= A_ALM_HI);
    assign mode_cur  = q.ctrl;
    assign mute_cur  = q.mute;
    assign alarm_cur = q.alarm;

    rtc_prescaler #(.DIV_STEPS(DIV_STEPS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .run      (q.ctrl[3]),
        .clr      (div_clr),
        .sec_step (sec_step)
    );

    rtc_time_core u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sec_step),
        .mode24   (q.h24),
        .wr_en    (time_we),
        .wr_idx   (bus_addr),
        .wr_nib   (bus_wdata),
        .leap_we  (leap_we),
        .leap_nib (bus_wdata[1:0]),
        .digits   (time_dig),
        .leap     (leap)
    );

    for (genvar b = 0; b < RAM_BLOCKS; b++) begin : g_ram
        rtc_nibble_ram #(.DEPTH(LOW_REGS)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ram_we[b]),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .rdata (ram_rd[b])
        );
    end

    // write decode and register next state
    always_comb begin
        d       = q;
        time_we = 1'b0;
        leap_we = 1'b0;
        div_clr = 1'b0;
        ram_we  = '0;
        if (bus_we) begin
            if (low_addr) begin
                case (bank)
                    BANK_TIME: time_we = 1'b1;
                    BANK_CFG: begin
                        if (in_alm)                d.alarm[aidx] = bus_wdata;
                        else if (bus_addr == A_H24)  d.h24 = bus_wdata[0];
                        else if (bus_addr == A_LEAP) leap_we = 1'b1;
                    end
                    BANK_RAMA: ram_we[0] = 1'b1;
                    BANK_RAMB: ram_we[1] = 1'b1;
                    default: ;
                endcase
            end else begin
                case (bus_addr)
                    A_CTRL: d.ctrl = bus_wdata;
                    A_TEST: d.test = bus_wdata;
                    A_ACT: begin
                        d.mute  = bus_wdata[3:2];
                        div_clr = bus_wdata[1];
                        if (bus_wdata[0]) d.alarm = '0;
                    end
                    default: ;
                endcase
            end
        end
        d.p16 = osc_tick & ~q.mute[0];
        d.p1  = sec_step & ~q.mute[1];
    end

    // read mux
    always_comb begin
        bus_rdata = 4'd0;
        if (low_addr) begin
            case (bank)
                BANK_TIME: bus_rdata = time_dig[bus_addr];
                BANK_CFG: begin
                    if (in_alm)                bus_rdata = q.alarm[aidx];
                    else if (bus_addr == A_H24)  bus_rdata = {3'b000, q.h24};
                    else if (bus_addr == A_LEAP) bus_rdata = {2'b00, leap};
                end
                BANK_RAMA: bus_rdata = ram_rd[0];
                BANK_RAMB: bus_rdata = ram_rd[1];
                default: ;
            endcase
        end else begin
            case (bus_addr)
                A_CTRL:  bus_rdata = q.ctrl;
                A_TEST:  bus_rdata = q.test;
                A_ACT:   bus_rdata = {q.mute, 2'b00};
                default: bus_rdata = 4'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.h24 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign alarm_hit  = q.ctrl[2]
                      && (time_dig[D_S1] == 4'd0) && (time_dig[D_S10] == 4'd0)
                      && (q.alarm == time_dig[A_ALM_HI:A_ALM_LO]);
    assign pulse_16hz = q.p16;
    assign pulse_1hz  = q.p1;
endmodule

// File: rtl/banked_rtc_chk.sv
module banked_rtc_chk
    import rtc_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       osc_tick,
    input logic [3:0]                 bus_addr,
    input logic [3:0]                 bus_wdata,
    input logic                       bus_we,
    input logic                       alarm_hit,
    input logic                       pulse_16hz,
    input logic                       pulse_1hz,
    input logic [3:0]                 mode_cur,
    input logic [1:0]                 mute_cur,
    input logic [ALM_REGS-1:0][3:0]   alarm_cur,
    input logic [LOW_REGS-1:0][3:0]   time_dig
);
    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=> (mode_cur == $past(bus_wdata)));

    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cur[3] && !bus_we) |=> $stable(time_dig));

    a_r9_alarm_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> mode_cur[2]);

    a_r10_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ACT && bus_wdata[0]) |=> (alarm_cur == '0));

    a_r11_fast_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && !mute_cur[0]) |=> pulse_16hz);

    a_r11_slow_pulse_running: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_1hz |-> $past(mode_cur[3]));
endmodule

bind banked_rtc banked_rtc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .alarm_hit  (alarm_hit),
    .pulse_16hz (pulse_16hz),
    .pulse_1hz  (pulse_1hz),
    .mode_cur   (mode_cur),
    .mute_cur   (mute_cur),
    .alarm_cur  (alarm_cur),
    .time_dig   (time_dig)
);

// File: tb/banked_rtc_tb.sv
module banked_rtc_tb;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [3:0] bus_wdata = 4'd0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_rdata;
    logic       alarm_hit, pulse_16hz, pulse_1hz;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    banked_rtc #(.DIV_STEPS(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .alarm_hit(alarm_hit),
        .pulse_16hz(pulse_16hz), .pulse_1hz(pulse_1hz)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [3:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic tick(output logic p16, output logic p1);
        osc_tick = 1'b1;
        @(negedge clk);
        p16 = pulse_16hz;
        p1  = pulse_1hz;
        osc_tick = 1'b0;
    endtask

    task automatic ticks(input int n, output logic last_p1);
        logic a, b;
        last_p1 = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(a, b);
            last_p1 = b;
        end
    endtask

    task automatic set_hms(input logic [3:0] h10, input logic [3:0] h1, input int mm, input int ss);
        wr(4'h0, 4'(ss % 10)); wr(4'h1, 4'(ss / 10));
        wr(4'h2, 4'(mm % 10)); wr(4'h3, 4'(mm / 10));
        wr(4'h4, h1);          wr(4'h5, h10);
    endtask

    task automatic set_date(input int dd, input int mo, input int yy, input logic [3:0] dow);
        wr(4'h7, 4'(dd % 10)); wr(4'h8, 4'(dd / 10));
        wr(4'h9, 4'(mo % 10)); wr(4'hA, 4'(mo / 10));
        wr(4'hB, 4'(yy % 10)); wr(4'hC, 4'(yy / 10));
        wr(4'h6, dow);
    endtask

    task automatic t_reset_state;
        rd_chk(4'hD, 4'h0, "R1 ctrl");
        for (int i = 0; i < 13; i++)
            rd_chk(4'(i), (i == 7 || i == 9) ? 4'd1 : 4'd0, "R1 time digit");
    endtask

    task automatic t_banks_ram;
        wr(4'hD, 4'h2);
        for (int i = 0; i < 13; i++) wr(4'(i), 4'(i + 1));
        wr(4'hD, 4'h3);
        for (int i = 0; i < 13; i++) wr(4'(i), 4'(14 - i));
        wr(4'hE, 4'hA);
        rd_chk(4'hD, 4'h3, "R2 ctrl readback");
        for (int i = 0; i < 13; i++) rd_chk(4'(i), 4'(14 - i), "R3 block B");
        wr(4'hD, 4'h2);
        for (int i = 0; i < 13; i++) rd_chk(4'(i), 4'(i + 1), "R3 block A");
        wr(4'hD, 4'h0);
        rd_chk(4'hE, 4'hA, "R2 test nibble shared");
        rd_chk(4'h7, 4'h1, "R2 time bank restored");
    endtask

    task automatic t_year_roll;
        logic p;
        wr(4'hD, 4'h0);
        set_hms(4'd2, 4'd3, 59, 59);
        set_date(31, 12, 99, 4'd6);
        rd_chk(4'h1, 4'd5, "R8 digit load");
        rd_chk(4'hC, 4'd9, "R8 digit load");
        ticks(DIV, p);
        rd_chk(4'h0, 4'd9, "R4 hold while stopped");
        wr(4'hD, 4'h8);
        ticks(DIV, p);
        for (int i = 0; i < 6; i++) rd_chk(4'(i), 4'd0, "R5 rollover to midnight");
        rd_chk(4'h6, 4'd0, "R7 dow wrap");
        rd_chk(4'h7, 4'd1, "R7 day to 1");
        rd_chk(4'h8, 4'd0, "R7 day tens");
        rd_chk(4'h9, 4'd1, "R7 month to 1");
        rd_chk(4'hA, 4'd0, "R7 month tens");
        rd_chk(4'hB, 4'd0, "R7 year wrap");
        rd_chk(4'hC, 4'd0, "R7 year wrap");
        wr(4'hD, 4'h9);
        rd_chk(4'hB, 4'd1, "R7 leap counter step");
        wr(4'hD, 4'h8);
    endtask

    task automatic t_drop_and_clear;
        logic p;
        ticks(DIV, p);
        rd_chk(4'h0, 4'd1, "R4 one second");
        wr(4'hD, 4'h0);
        ticks(DIV, p);
        wr(4'hD, 4'h8);
        ticks(DIV, p);
        rd_chk(4'h0, 4'd2, "R4 no catch-up");
        ticks(5, p);
        wr(4'hF, 4'h2);
        ticks(DIV - 1, p);
        rd_chk(4'h0, 4'd2, "R10 prescaler restart");
        ticks(1, p);
        rd_chk(4'h0, 4'd3, "R10 prescaler restart");
    endtask

    task automatic t_feb;
        logic p;
        wr(4'hD, 4'h9); wr(4'hB, 4'd0); wr(4'hD, 4'h8);
        set_hms(4'd2, 4'd3, 59, 59); set_date(28, 2, 24, 4'd1);
        ticks(DIV, p);
        rd_chk(4'h8, 4'd2, "R7 feb 29 leap");
        rd_chk(4'h7, 4'd9, "R7 feb 29 leap");
        rd_chk(4'h9, 4'd2, "R7 still feb");
        set_hms(4'd2, 4'd3, 59, 59); set_date(29, 2, 24, 4'd1);
        ticks(DIV, p);
        rd_chk(4'h7, 4'd1, "R7 leap march");
        rd_chk(4'h9, 4'd3, "R7 leap march");
        wr(4'hD, 4'h9); wr(4'hB, 4'd1); wr(4'hD, 4'h8);
        set_hms(4'd2, 4'd3, 59, 59); set_date(28, 2, 25, 4'd1);
        ticks(DIV, p);
        rd_chk(4'h7, 4'd1, "R7 common-year march");
        rd_chk(4'h9, 4'd3, "R7 common-year march");
        set_hms(4'd2, 4'd3, 59, 59); set_date(30, 4, 25, 4'd1);
        ticks(DIV, p);
        rd_chk(4'h7, 4'd1, "R7 april end");
        rd_chk(4'h9, 4'd5, "R7 april end");
    endtask

    task automatic t_twelve_hour;
        logic p;
        wr(4'hD, 4'h9); wr(4'hA, 4'd0);
        rd_chk(4'hA, 4'd0, "R6 mode select readback");
        wr(4'hD, 4'h8);
        set_hms(4'd1, 4'd1, 59, 59);
        ticks(DIV, p);
        rd_chk(4'h5, 4'd3, "R6 11AM to 12PM");
        rd_chk(4'h4, 4'd2, "R6 11AM to 12PM");
        set_hms(4'd3, 4'd2, 59, 59);
        ticks(DIV, p);
        rd_chk(4'h5, 4'd2, "R6 12PM to 1PM");
        rd_chk(4'h4, 4'd1, "R6 12PM to 1PM");
        set_hms(4'd3, 4'd1, 59, 59); set_date(10, 1, 30, 4'd2);
        ticks(DIV, p);
        rd_chk(4'h5, 4'd1, "R6 11PM to 12AM");
        rd_chk(4'h4, 4'd2, "R6 11PM to 12AM");
        rd_chk(4'h7, 4'd1, "R6 day carry");
        rd_chk(4'h8, 4'd1, "R6 day carry");
        rd_chk(4'h6, 4'd3, "R7 dow step");
        wr(4'hD, 4'h9); wr(4'hA, 4'd1); wr(4'hD, 4'h8);
    endtask

    task automatic t_alarm;
        wr(4'hD, 4'h1);
        wr(4'h2, 4'd0); wr(4'h3, 4'd3); wr(4'h4, 4'd7); wr(4'h5, 4'd0);
        wr(4'h6, 4'd1); wr(4'h7, 4'd5); wr(4'h8, 4'd1);
        wr(4'hD, 4'h4);
        set_hms(4'd0, 4'd7, 30, 0); set_date(15, 6, 30, 4'd1);
        check("R9 match", {3'b0, alarm_hit}, 4'd1);
        wr(4'h0, 4'd1);
        check("R9 seconds nonzero", {3'b0, alarm_hit}, 4'd0);
        wr(4'h0, 4'd0);
        check("R9 match again", {3'b0, alarm_hit}, 4'd1);
        wr(4'hD, 4'h0);
        check("R9 disabled", {3'b0, alarm_hit}, 4'd0);
        wr(4'hD, 4'h5);
        check("R9 enabled", {3'b0, alarm_hit}, 4'd1);
        wr(4'hF, 4'h1);
        check("R10 clear drops match", {3'b0, alarm_hit}, 4'd0);
        rd_chk(4'h3, 4'd0, "R10 alarm cleared");
        rd_chk(4'h7, 4'd0, "R10 alarm cleared");
    endtask

    task automatic t_pulses;
        logic p16, p1;
        wr(4'hD, 4'h8); wr(4'hF, 4'h0);
        tick(p16, p1);
        check("R11 fast pulse", {3'b0, p16}, 4'd1);
        check("R11 no slow pulse mid-second", {3'b0, p1}, 4'd0);
        wr(4'hF, 4'h4);
        rd_chk(4'hF, 4'h4, "R10 mute readback");
        tick(p16, p1);
        check("R10 fast pulse muted", {3'b0, p16}, 4'd0);
        wr(4'hF, 4'h2);
        ticks(DIV, p1);
        check("R11 slow pulse", {3'b0, p1}, 4'd1);
        wr(4'hF, 4'hA);
        rd_chk(4'hF, 4'h8, "R10 mute readback");
        ticks(DIV, p1);
        check("R10 slow pulse muted", {3'b0, p1}, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_banks_ram;
        t_year_roll;
        t_drop_and_clear;
        t_feb;
        t_twelve_hour;
        t_alarm;
        t_pulses;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule